// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is one channel that sits beside a free-running timer counter. It watches the counter value on every clock and works in one of two ways. In capture mode it copies the counter into its capture/compare register whenever the chosen input shows the chosen kind of edge. It raises the channel's interrupt flag on each capture. It also keeps track of whether a captured value has been read before the next capture replaces it. In compare mode it holds a software-written value, drives an equality strobe while the counter matches that value, and sets the interrupt flag.

Software reaches the channel through a small register port. A strobe selects one of two words: address 0 holds the control word and address 1 holds the capture/compare value. Read data is combinational and appears in the same cycle as the read strobe. The port has no back-pressure: every strobe is accepted in the cycle it is presented, so no ready signal exists and none is needed. The capture source can be one of two external inputs or a fixed low or high level. When both edges are enabled, software can force a capture by flipping the level select between low and high.

Top module: `ccch_channel`

## Requirements
- R1: After reset, the control word reads 0 (compare mode, all fields clear), the capture/compare value reads 0, and `irq_flag` is 0.
- R2: Control word layout, address 0, `reg_addr`=0. Bit 0 is the mode (1 = capture, 0 = compare). Bits 2:1 are the edge select. Bits 4:3 are the source select. Bit 5 is the interrupt flag. Bit 6 is the overflow bit. Reads return these bits, with zeros above them, in the same cycle as `reg_rd`. Writes load bits 4:0.
- R3: Source select: when bit 4 is 0, bit 3 picks `cap_in[0]` or `cap_in[1]`. When bit 4 is 1, bit 3 is the level itself (0 = low, 1 = high), and the external inputs have no effect.
- R4: Edge select: 0 never captures, 1 captures on rising edges, 2 captures on falling edges, 3 captures on both.
- R5: A qualifying source change that appears before clock edge k is captured at edge k+2. At that edge the register loads the current `cnt_val` and `irq_flag` is set.
- R6: A capture while a previous capture is still unread sets the overflow bit (bit 6).
- R7: Reading address 1 after a capture, with no capture in that same cycle, returns the channel to idle. The next single capture then leaves the overflow bit at 0.
- R8: A control write with bit 6 = 0 clears the overflow bit and returns the channel to idle. A write with bit 6 = 1 leaves the overflow bit unchanged.
- R9: A read of address 1 in the same cycle as a capture returns the newly captured counter value. It leaves the channel holding an unread capture, so a further capture sets the overflow bit.
- R10: `equ` is 1 exactly in the cycles where the mode is compare and `cnt_val` equals the stored value. It is never 1 in capture mode.
- R11: In compare mode, a clock edge with `equ` = 1 sets `irq_flag`. The flag stays set until a control write with bit 5 = 0 clears it. A control write with bit 5 = 1 leaves it set.
- R12: A write to address 1 takes effect for the equality check in the cycle after the write edge.
- R13: In compare mode, edges on the capture source neither load the register nor set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (address 1 read feeds overflow tracking) |
| reg_addr | input | 1 | 0 = control word, 1 = capture/compare value |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Read data, combinational, 0 when not reading |
| cnt_val | input | CNT_W | Current timer counter value |
| cap_in | input | 2 | External capture inputs |
| irq_flag | output | 1 | Channel interrupt flag |
| equ | output | 1 | Counter-equals-compare-value strobe |

## Verification
The timings are as follows. A source change becomes a capture at the third rising edge after it appears. A source-select write makes its capture at the third edge after the write edge. The equality strobe follows `cnt_val` within the same cycle. The flag follows the strobe one edge later. Read data is valid in the cycle of the read strobe. A behavioural model in the bench steps on every rising edge, and outputs are compared at each falling edge. The directed checks drive inputs just after a falling edge and sample either at the next falling edge or one nanosecond after a read strobe. The same-cycle read case places the read strobe exactly on the capture cycle by counting falling edges from the write.

// File: rtl/ccch_pkg.sv
package ccch_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CAPT = 2'd1,
    ST_OVF  = 2'd2
  } cap_st_e;

  // control word bit positions
  localparam int CTL_MODE   = 0;
  localparam int CTL_FIELDS = 5;
  localparam int CTL_FLAG   = 5;
  localparam int CTL_OVF    = 6;
  localparam int CTL_W      = 7;

  localparam int N_EXT = 2;

  typedef struct packed {
    logic [1:0] sel;
    logic [1:0] edg;
    logic       mode;
  } ctl_t;

endpackage

// File: rtl/ccch_edge_det.sv
module ccch_edge_det #(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       raw,
  input  logic       en,
  input  logic [1:0] edg,
  output logic       pulse
);
  logic [STAGES-1:0] chain;
  logic              last;
  logic              rise;
  logic              fall;

  if (STAGES == 1) begin : g_one
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= raw;
    end
  end else begin : g_many
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], raw};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last <= 1'b0;
    else        last <= chain[STAGES-1];
  end

  assign rise  = chain[STAGES-1] & ~last;
  assign fall  = ~chain[STAGES-1] & last;
  assign pulse = en & ((edg[0] & rise) | (edg[1] & fall));

  // an edge pulse always needs a change of the synchronized level
  assert_pulse_on_change_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> !$stable(chain[STAGES-1]));

endmodule

// File: rtl/ccch_ovf_fsm.sv
module ccch_ovf_fsm
  import ccch_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    cap,
  input  logic    rd,
  input  logic    clr,
  output cap_st_e st
);
  cap_st_e base;
  cap_st_e st_n;

  always_comb begin
    base = clr ? ST_IDLE : st;
    st_n = base;
    unique case (base)
      ST_IDLE: if (cap) st_n = ST_CAPT;
      ST_CAPT: begin
        if (cap)     st_n = rd ? ST_CAPT : ST_OVF;
        else if (rd) st_n = ST_IDLE;
      end
      ST_OVF:  st_n = ST_OVF;
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_n;
  end

  assert_ovf_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st == ST_OVF) |-> $past(st == ST_CAPT && cap && !rd && !clr));

  assert_read_releases_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CAPT && rd && !cap && !clr) |=> st == ST_IDLE);

  assert_clear_idles_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !cap) |=> st == ST_IDLE);

endmodule

// File: rtl/ccch_cmp.sv
module ccch_cmp #(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] ref_val,
  input  logic             mode,
  output logic             hit
);
  assign hit = ~mode & (cnt == ref_val);
endmodule

// File: rtl/ccch_channel.sv
module ccch_channel
  import ccch_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic             reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic [N_EXT-1:0] cap_in,
  output logic             irq_flag,
  output logic             equ
);
  localparam int PAD_W = CNT_W - CTL_W;

  ctl_t             ctl_q;
  logic [CNT_W-1:0] ccr_q;
  logic             flag_q;
  cap_st_e          st;
  logic             ctl_wr;
  logic             ccr_wr;
  logic             ccr_rd;
  logic             ovf_clr;
  logic             flag_clr;
  logic             src;
  logic             cap_ev;
  logic [CTL_W-1:0] ctl_word;

  assign ctl_wr   = reg_wr & ~reg_addr;
  assign ccr_wr   = reg_wr &  reg_addr;
  assign ccr_rd   = reg_rd &  reg_addr;
  assign ovf_clr  = ctl_wr & ~reg_wdata[CTL_OVF];
  assign flag_clr = ctl_wr & ~reg_wdata[CTL_FLAG];

  // source: fixed level or one external pin
  assign src = ctl_q.sel[1] ? ctl_q.sel[0] : cap_in[ctl_q.sel[0]];

  ccch_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .raw   (src),
    .en    (ctl_q.mode),
    .edg   (ctl_q.edg),
    .pulse (cap_ev)
  );

  ccch_ovf_fsm u_fsm (
    .clk   (clk),
    .rst_n (rst_n),
    .cap   (cap_ev),
    .rd    (ccr_rd),
    .clr   (ovf_clr),
    .st    (st)
  );

  ccch_cmp #(.CNT_W(CNT_W)) u_cmp (
    .cnt     (cnt_val),
    .ref_val (ccr_q),
    .mode    (ctl_q.mode),
    .hit     (equ)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_wr) ctl_q <= ctl_t'(reg_wdata[CTL_FIELDS-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ccr_q <= '0;
    else if (cap_ev) ccr_q <= cnt_val;
    else if (ccr_wr) ccr_q <= reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= (flag_q & ~flag_clr) | cap_ev | equ;
  end

  assign irq_flag = flag_q;
  assign ctl_word = {st == ST_OVF, flag_q, ctl_q.sel, ctl_q.edg, ctl_q.mode};

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      if (reg_addr) reg_rdata = cap_ev ? cnt_val : ccr_q;
      else          reg_rdata = {{PAD_W{1'b0}}, ctl_word};
    end
  end

  assert_capture_loads_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cap_ev |=> (ccr_q == $past(cnt_val)) && irq_flag);

  assert_no_capture_in_compare_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_q.mode |-> !cap_ev);

  assert_equ_sets_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    equ |=> irq_flag);

  assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !ctl_wr) |=> irq_flag);

  assert_value_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ccr_wr && !cap_ev) |=> ccr_q == $past(reg_wdata));

endmodule

// File: tb/ccch_channel_bench.sv
`timescale 1ns/1ps
module ccch_channel_bench;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_wr = 1'b0;
  logic         reg_rd = 1'b0;
  logic         reg_addr = 1'b0;
  logic [W-1:0] reg_wdata = '0;
  logic [W-1:0] reg_rdata;
  logic [W-1:0] cnt_val = 16'd1000;
  logic [1:0]   cap_in = 2'b00;
  logic         irq_flag;
  logic         equ;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ccch_channel u_ccch_channel (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cnt_val(cnt_val), .cap_in(cap_in), .irq_flag(irq_flag), .equ(equ)
  );

  // ---------------- behavioural reference model ----------------
  bit       m_mode;
  bit [1:0] m_edg, m_sel;
  bit       m_s0, m_s1, m_last;
  bit       m_flag;
  int       m_st;             // 0 idle, 1 captured, 2 overflow
  bit [W-1:0] m_ccr;

  function automatic bit m_src();
    if (m_sel[1]) return m_sel[0];
    return cap_in[m_sel[0]];
  endfunction

  function automatic bit m_cap();
    bit r, f;
    r = m_s1 && !m_last;
    f = !m_s1 && m_last;
    return m_mode && ((m_edg == 2'd1 && r) || (m_edg == 2'd2 && f) || (m_edg == 2'd3 && (r || f)));
  endfunction

  function automatic bit m_equ();
    return !m_mode && (cnt_val == m_ccr);
  endfunction

  function automatic bit [W-1:0] m_rdata();
    bit [W-1:0] v;
    v = '0;
    if (reg_rd) begin
      if (reg_addr) v = m_cap() ? cnt_val : m_ccr;
      else v = {9'd0, (m_st == 2), m_flag, m_sel, m_edg, m_mode};
    end
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_edg = 0; m_sel = 0; m_s0 = 0; m_s1 = 0; m_last = 0;
      m_flag = 0; m_st = 0; m_ccr = '0;
    end else begin
      bit c, e, cw, rd;
      int base;
      c  = m_cap();
      e  = m_equ();
      cw = reg_wr && !reg_addr;
      rd = reg_rd && reg_addr;
      base = (cw && !reg_wdata[6]) ? 0 : m_st;
      m_st = base;
      if (base == 0 && c) m_st = 1;
      else if (base == 1) begin
        if (c) m_st = rd ? 1 : 2;
        else if (rd) m_st = 0;
      end
      m_flag = (m_flag && !(cw && !reg_wdata[5])) || c || e;
      m_last = m_s1; m_s1 = m_s0; m_s0 = m_src();
      if (c) m_ccr = cnt_val;
      else if (reg_wr && reg_addr) m_ccr = reg_wdata;
      if (cw) begin
        m_mode = reg_wdata[0]; m_edg = reg_wdata[2:1]; m_sel = reg_wdata[4:3];
      end
    end
  end

  task automatic check(input string tag, input longint act, input longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R11 flag vs model", irq_flag, m_flag);
      check("R10 equ vs model", equ, m_equ());
      check("R9 rdata vs model", reg_rdata, m_rdata());
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); #1; end
  endtask

  task automatic wr_reg(input bit a, input logic [W-1:0] d);
    @(negedge clk); #1; reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); #1; reg_wr = 0;
  endtask

  task automatic rd_reg(input bit a, output logic [W-1:0] v);
    @(negedge clk); #1; reg_rd = 1; reg_addr = a;
    #1 v = reg_rdata;
    @(negedge clk); #1; reg_rd = 0;
  endtask

  initial begin
    logic [W-1:0] v;
    step(3);
    rst_n = 1;
    step(1);
    // R1 reset state
    rd_reg(0, v); check("R1 control after reset", v, 0);
    rd_reg(1, v); check("R1 value after reset", v, 0);
    check("R1 flag after reset", irq_flag, 0);

    // R2 layout: capture mode, rising, ext0
    wr_reg(0, 16'h0043);
    rd_reg(0, v); check("R2 control readback", v, 16'h0003);

    // R5 capture latency on rising edge of cap_in[0]
    cnt_val = 16'h1234;
    cap_in[0] = 1;
    step(1); check("R5 no flag after 1 edge", irq_flag, 0);
    step(1); check("R5 no flag after 2 edges", irq_flag, 0);
    step(1); check("R5 flag after 3 edges", irq_flag, 1);
    rd_reg(1, v); check("R5 captured value", v, 16'h1234);

    // R4 falling edge ignored in rising mode
    wr_reg(0, 16'h0043);           // clear flag
    cnt_val = 16'h2222;
    cap_in[0] = 0; step(6);
    check("R4 falling ignored flag", irq_flag, 0);
    rd_reg(1, v); check("R4 falling ignored value", v, 16'h1234);
    // R4 falling mode
    wr_reg(0, 16'h0045);
    cap_in[0] = 1; step(6);
    check("R4 rising ignored in falling mode", irq_flag, 0);
    cnt_val = 16'h2323;
    cap_in[0] = 0; step(6);
    check("R4 falling captured flag", irq_flag, 1);
    rd_reg(1, v); check("R4 falling captured value", v, 16'h2323);

    // R3 fixed levels, both edges
    wr_reg(0, 16'h0057);           // const low, flag clear
    step(4);
    cnt_val = 16'h3300;
    wr_reg(0, 16'h005F);           // const high -> capture
    step(4);
    rd_reg(1, v); check("R3 software capture value", v, 16'h3300);
    wr_reg(0, 16'h005F);           // clear flag, keep level
    cap_in = 2'b11; step(6); cap_in = 2'b00; step(6);
    check("R3 external ignored under fixed level", irq_flag, 0);

    // R6 overflow: two captures without a read
    wr_reg(0, 16'h0057); step(5);
    wr_reg(0, 16'h005F); step(5);
    rd_reg(0, v); check("R6 overflow bit set", v[6], 1);

    // R8 clearing by control write with bit 6 low
    wr_reg(0, 16'h001F); step(1);
    rd_reg(0, v); check("R8 overflow cleared", v[6], 0);
    wr_reg(0, 16'h0057); step(5);
    rd_reg(0, v); check("R8 single capture no overflow", v[6], 0);
    wr_reg(0, 16'h0040); step(2);  // bit6 high: no effect on idle state
    wr_reg(0, 16'h0057); step(3);

    // R7 read returns to idle
    rd_reg(1, v);
    wr_reg(0, 16'h005F); step(5);
    rd_reg(0, v); check("R7 read then capture no overflow", v[6], 0);

    // R9 read in the capture cycle (channel currently captured, unread)
    cnt_val = 16'h4949;
    wr_reg(0, 16'h0057);
    step(2);
    reg_rd = 1; reg_addr = 1;
    #1 check("R9 same-cycle read returns new value", reg_rdata, 16'h4949);
    @(negedge clk); #1; reg_rd = 0;
    rd_reg(0, v); check("R9 same-cycle read keeps no overflow", v[6], 0);
    wr_reg(0, 16'h005F); step(5);
    rd_reg(0, v); check("R9 left captured so next capture overflows", v[6], 1);

    // R13 compare mode ignores source edges
    wr_reg(1, 16'h7000);
    wr_reg(0, 16'h0016); step(5);  // compare mode, both, const low; clear flag/ovf
    wr_reg(0, 16'h005E); step(6);
    check("R13 no flag in compare mode", irq_flag, 0);
    rd_reg(1, v); check("R13 value unchanged", v, 16'h7000);

    // R10 / R11 equality and sticky flag
    cnt_val = 16'h6FFF; step(1);
    check("R10 equ low before match", equ, 0);
    cnt_val = 16'h7000; #1;
    check("R10 equ high on match", equ, 1);
    check("R11 flag not yet set", irq_flag, 0);
    step(1); check("R11 flag set after match edge", irq_flag, 1);
    cnt_val = 16'h7001; #1;
    check("R10 equ low after match", equ, 0);
    step(3); check("R11 flag holds", irq_flag, 1);
    wr_reg(0, 16'h0036); step(1);
    check("R11 write bit5=1 keeps flag", irq_flag, 1);
    wr_reg(0, 16'h0016); step(1);
    check("R11 write bit5=0 clears flag", irq_flag, 0);
    for (int i = 0; i < 12; i++) begin @(negedge clk); #1; cnt_val = 16'h6FFA + i; end

    // R12 compare value write
    cnt_val = 16'h5555; step(1);
    check("R12 equ low before write", equ, 0);
    wr_reg(1, 16'h5555);
    check("R12 equ high after write", equ, 1);

    // R10 no equ in capture mode
    wr_reg(0, 16'h0057); #1;
    check("R10 equ low in capture mode", equ, 0);
    step(4);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule